// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Engine

This block sits between a simple host request port and an external asynchronous parallel memory with a 16-bit data bus. Address and data travel on separate lines. The host presents one half-word read or write at a time with a valid/ready handshake. The block then runs one complete bus cycle. Each access has two phases. The first is an address phase: chip enable is asserted and the address is driven. The second is a data phase: output enable (for reads) or write enable (for writes) is asserted. The length of each phase is a parameter counted in clock cycles, and no address-hold or turnaround cycles are added.

The host addresses half-words. Index N appears on the bus as byte address 2*N. A read returns the sampled bus data with a one-cycle valid pulse. A write ends with a one-cycle done pulse. The bidirectional data bus is split into an input, an output and an output-drive enable, which the chip pad ring combines.

Top module: `amem_bus_engine`

## Requirements
- R1: After reset and whenever no access is in progress, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, rd_valid and wr_done are 0, and req_ready is 1.
- R2: req_ready is 0 for every cycle in which mem_ce_n is 0. A request presented during that time is held off and is neither lost nor started early.
- R3: Every access begins with an address phase of ADDSET_CYC cycles (default 2). In this phase mem_ce_n is 0 and both mem_oe_n and mem_we_n are 1.
- R4: The address phase is followed by a data phase of DATASET_CYC cycles (default 5). mem_oe_n is 0 in this phase on a read and mem_we_n is 0 on a write. The two are never 0 together.
- R5: On a write, mem_we_n is 0 only in the data phase. mem_dq_oe is 1 and mem_dq_out holds the request data for the whole access. On a read, mem_dq_oe stays 0.
- R6: mem_addr equals twice the host half-word index (bit 0 is 0) and stays stable for the whole access.
- R7: A read samples mem_dq_in at the clock edge that ends the last data-phase cycle. In the following cycle, rd_valid is 1 for exactly one cycle and rd_data carries the sample.
- R8: A write raises wr_done for exactly one cycle, in the cycle right after the data phase. rd_valid and wr_done are never 1 together.
- R9: A request held valid across an access is accepted in the cycle in which the previous completion pulse is high, leaving exactly one cycle with mem_ce_n at 1 between the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host half-word index |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| wr_done | output | 1 | One-cycle write completion pulse |
| mem_addr | output | ADDR_W+1 | Byte address on the bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
Two events can fall in the same cycle: the completion pulse of one access (rd_valid or wr_done) and the acceptance of the next request. The bench provokes this by holding req_valid high through a mixed burst of reads and writes, so that each following request is already waiting when the current access ends. It then checks that exactly one idle cycle separates consecutive chip-enable intervals. The scoreboard must still pair every completion pulse with the right data, in order. The bench's memory model drives valid read data only in the final data-phase cycle, which shows whether the sampling edge is early.

// File: rtl/amem_pkg.sv
// Shared definitions for the asynchronous memory bus engine.
// Assumes a single clock domain; holds only types and helpers.
package amem_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } amem_phase_e;

    function automatic int amem_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/amem_phase_timer.sv
// Down-counter shared by both bus phases.
// A load sets the remaining cycles minus one; 'last' marks the final cycle
// of the phase that was loaded. Assumes load values are below 2**CNT_W.
module amem_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Count the current phase down to zero, reloading at phase starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/amem_access_fsm.sv
// Phase sequencer: idle -> address phase -> data phase -> idle.
// Strobes are decoded from the registered phase and the latched operation,
// so they change only after clock edges. Assumes both cycle counts >= 1.
module amem_access_fsm
    import amem_pkg::*;
#(
    parameter int ADDSET_CYC  = 2,
    parameter int DATASET_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic op_wr,
    output logic req_ready,
    output logic accept,
    output logic finish,
    output logic mem_ce_n,
    output logic mem_oe_n,
    output logic mem_we_n,
    output logic mem_dq_oe
);

    localparam int CNT_W = $clog2(amem_max(ADDSET_CYC, DATASET_CYC) + 1);
    localparam logic [CNT_W-1:0] ADDR_LOAD = CNT_W'(ADDSET_CYC - 1);
    localparam logic [CNT_W-1:0] DATA_LOAD = CNT_W'(DATASET_CYC - 1);

    amem_phase_e phase_q, phase_d;
    logic        t_load, t_last;
    logic [CNT_W-1:0] t_val;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign finish    = (phase_q == PH_DATA) && t_last;

    // Timer is reloaded when a request is taken and when the data phase opens.
    assign t_load = accept || ((phase_q == PH_ADDR) && t_last);
    assign t_val  = accept ? ADDR_LOAD : DATA_LOAD;

    amem_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (accept) phase_d = PH_ADDR;
            PH_ADDR: if (t_last) phase_d = PH_DATA;
            PH_DATA: if (t_last) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Bus strobe decode from the registered phase.
    always_comb begin
        mem_ce_n  = (phase_q == PH_IDLE);
        mem_oe_n  = !((phase_q == PH_DATA) && !op_wr);
        mem_we_n  = !((phase_q == PH_DATA) &&  op_wr);
        mem_dq_oe = (phase_q != PH_IDLE) && op_wr;
    end

endmodule

// File: rtl/amem_datapath.sv
// Request capture and read return.
// Address, write data and direction are latched at acceptance and held for
// the whole access. The half-word index is shifted to a byte address.
module amem_datapath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int BA_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              finish,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              op_wr,
    output logic [BA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              wr_done
);

    logic [ADDR_W-1:0] addr_q;

    // Hold the request fields for the duration of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            mem_dq_out <= '0;
            op_wr      <= 1'b0;
        end else if (accept) begin
            addr_q     <= req_addr;
            mem_dq_out <= req_wdata;
            op_wr      <= req_write;
        end
    end

    assign mem_addr = BA_W'({addr_q, 1'b0});

    // Sample the bus on the closing edge of the data phase; pulse completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            wr_done  <= 1'b0;
        end else begin
            rd_valid <= finish && !op_wr;
            wr_done  <= finish &&  op_wr;
            if (finish && !op_wr) rd_data <= mem_dq_in;
        end
    end

endmodule

// File: rtl/amem_bus_engine.sv
// Top level: one host half-word request becomes one asynchronous bus access
// with a fixed address phase and data phase, without hold or turnaround.
// Assumes a 16-bit non-multiplexed memory; the pad ring merges dq in/out/oe.
module amem_bus_engine #(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int ADDSET_CYC  = 2,
    parameter int DATASET_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done,
    output logic [ADDR_W:0]   mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int BA_W = ADDR_W + 1;

    logic accept, finish, op_wr;

    amem_access_fsm #(
        .ADDSET_CYC  (ADDSET_CYC),
        .DATASET_CYC (DATASET_CYC)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .op_wr     (op_wr),
        .req_ready (req_ready),
        .accept    (accept),
        .finish    (finish),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_oe (mem_dq_oe)
    );

    amem_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BA_W   (BA_W)
    ) i_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .finish     (finish),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .op_wr      (op_wr),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .wr_done    (wr_done)
    );

endmodule

// File: rtl/amem_bus_checks.sv
// Protocol checker bound to the top level; observes ports only.
module amem_bus_checks #(
    parameter int BA_W   = 21,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic [BA_W-1:0]   mem_addr,
    input logic              rd_valid,
    input logic              wr_done
);

    assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_busy_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    assert_we_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |=> (!mem_dq_oe || $stable(mem_dq_out)));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));

    assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_wr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !wr_done);

endmodule

bind amem_bus_engine amem_bus_checks #(
    .BA_W   (BA_W),
    .DATA_W (DATA_W)
) i_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_out (mem_dq_out),
    .mem_addr   (mem_addr),
    .rd_valid   (rd_valid),
    .wr_done    (wr_done)
);

// File: tb/test_amem_bus_engine.sv
module test_amem_bus_engine;

    localparam int ADDR_W = 20;
    localparam int DW     = 16;
    localparam int ASET   = 2;
    localparam int DSET   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, wr_done;
    logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
    logic [ADDR_W:0] mem_addr;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

    always #4 clk = ~clk;

    amem_bus_engine i_amem_bus_engine (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: read data is valid only in the last data-phase cycle.
    logic [DW-1:0] bmem [64];
    logic [DW-1:0] ref_mem [64];
    int oe_cnt = 0;
    initial for (int i = 0; i < 64; i++) begin
        bmem[i]    = DW'(i * 16'h0101) ^ 16'h3C00;
        ref_mem[i] = DW'(i * 16'h0101) ^ 16'h3C00;
    end
    always @(posedge clk) begin
        if (mem_oe_n) oe_cnt <= 0;
        else          oe_cnt <= oe_cnt + 1;
        if (!mem_we_n) bmem[mem_addr[6:1]] <= mem_dq_out;
    end
    assign mem_dq_in = (!mem_oe_n && oe_cnt == DSET - 1) ? bmem[mem_addr[6:1]] : 16'hDEAD;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] a;
        logic [DW-1:0]     d;
    } acc_t;
    acc_t q_acc[$];
    acc_t q_res[$];

    // Driver: present one request, push expectations, return after acceptance.
    task automatic issue(input bit wr, input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        acc_t it;
        it.wr = wr; it.a = a;
        if (wr) begin
            ref_mem[a[5:0]] = d;
            it.d = d;
        end else begin
            it.d = ref_mem[a[5:0]];
        end
        q_acc.push_back(it);
        q_res.push_back(it);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        req_valid = 1'b0;
        while (q_res.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: phase lengths, strobes, address and completion scoreboard.
    bit   prev_ce = 1'b1, prev_rdv = 1'b0, prev_wrd = 1'b0;
    bit   track_gap = 1'b0, gap_armed = 1'b0;
    int   a_cnt = 0, d_cnt = 0, gap = 0;
    bit   bad_r2 = 0, bad_r3 = 0, bad_r4 = 0, bad_r5 = 0, bad_r6 = 0;
    acc_t cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) begin
                if (prev_ce) begin
                    a_cnt = 0; d_cnt = 0;
                    bad_r2 = 0; bad_r3 = 0; bad_r4 = 0; bad_r5 = 0; bad_r6 = 0;
                    if (q_acc.size() == 0) begin
                        chk(0, "R2 access without request", 32'd1, 32'd0);
                        cur = '0;
                    end else begin
                        cur = q_acc.pop_front();
                    end
                    chk(mem_addr == {cur.a, 1'b0}, "R6 byte address", 32'(mem_addr), 32'({cur.a, 1'b0}));
                    if (track_gap && gap_armed) chk(gap == 1, "R9 back-to-back gap", 32'(gap), 32'd1);
                end
                if (req_ready) bad_r2 = 1;
                if (mem_oe_n && mem_we_n) begin
                    if (d_cnt != 0) bad_r3 = 1;
                    a_cnt++;
                end else begin
                    d_cnt++;
                end
                if (cur.wr && !mem_oe_n)  bad_r4 = 1;
                if (!cur.wr && !mem_we_n) bad_r4 = 1;
                if (cur.wr != mem_dq_oe)  bad_r5 = 1;
                if (cur.wr && mem_dq_out != cur.d) bad_r5 = 1;
                if (mem_addr != {cur.a, 1'b0}) bad_r6 = 1;
            end else begin
                if (!prev_ce) begin
                    chk(a_cnt == ASET && !bad_r3, "R3 address phase length", 32'(a_cnt), 32'(ASET));
                    chk(d_cnt == DSET, "R4 data phase length", 32'(d_cnt), 32'(DSET));
                    chk(!bad_r4, "R4 strobe for direction", 32'(bad_r4), 32'd0);
                    chk(!bad_r2, "R2 ready low while busy", 32'(bad_r2), 32'd0);
                    chk(!bad_r5, "R5 write drive and data hold", 32'(bad_r5), 32'd0);
                    chk(!bad_r6, "R6 address stable", 32'(bad_r6), 32'd0);
                    if (cur.wr) chk(wr_done, "R8 done in first idle cycle", 32'(wr_done), 32'd1);
                    else        chk(rd_valid, "R7 valid in first idle cycle", 32'(rd_valid), 32'd1);
                    gap = 1;
                    gap_armed = track_gap;
                end else begin
                    gap++;
                end
                if (!(mem_oe_n && mem_we_n && !mem_dq_oe && req_ready))
                    chk(0, "R1 idle outputs", {mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 32'hD);
            end
            if (rd_valid || wr_done) begin
                chk(!(rd_valid && wr_done), "R8 exclusive pulses", {rd_valid, wr_done}, 32'd0);
                if (q_res.size() == 0) begin
                    chk(0, "R7 unexpected completion", 32'd1, 32'd0);
                end else begin
                    acc_t e;
                    e = q_res.pop_front();
                    if (e.wr) chk(wr_done, "R8 write completion kind", 32'(wr_done), 32'd1);
                    else begin
                        chk(rd_valid, "R7 read completion kind", 32'(rd_valid), 32'd1);
                        chk(rd_data == e.d, "R7 read data", 32'(rd_data), 32'(e.d));
                    end
                end
            end
            if (rd_valid && prev_rdv) chk(0, "R7 pulse width", 32'd2, 32'd1);
            if (wr_done && prev_wrd)  chk(0, "R8 pulse width", 32'd2, 32'd1);
            prev_ce  = mem_ce_n;
            prev_rdv = rd_valid;
            prev_wrd = wr_done;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1 strobes high", 32'({mem_ce_n, mem_oe_n, mem_we_n}), 32'h7);
        chk(!mem_dq_oe && !rd_valid && !wr_done, "R1 no drive or pulses", 32'({mem_dq_oe, rd_valid, wr_done}), 32'd0);

        // Isolated writes, including index 0 and the largest index
        issue(1, 20'h00000, 16'hA5A5); settle();
        issue(1, 20'h00001, 16'hFFFF); settle();
        issue(1, 20'h00002, 16'h0000); settle();
        issue(1, 20'hFFFFF, 16'h1234); settle();
        issue(1, 20'h00025, 16'h5A5A); settle();

        // Isolated reads back, plus an untouched location
        issue(0, 20'h00000, 16'h0); settle();
        issue(0, 20'h00001, 16'h0); settle();
        issue(0, 20'h00002, 16'h0); settle();
        issue(0, 20'hFFFFF, 16'h0); settle();
        issue(0, 20'h00025, 16'h0); settle();
        issue(0, 20'h0000A, 16'h0); settle();

        // R9: requests held valid so acceptance meets the completion pulse
        track_gap = 1'b1;
        issue(1, 20'h00003, 16'hBEEF);
        issue(0, 20'h00003, 16'h0);
        issue(1, 20'h00004, 16'h0001);
        issue(0, 20'h00001, 16'h0);
        issue(0, 20'h00004, 16'h0);
        issue(1, 20'h00003, 16'h8001);
        issue(0, 20'h00003, 16'h0);
        settle();
        track_gap = 1'b0;

        chk(q_res.size() == 0 && q_acc.size() == 0, "R7 all completions returned",
            32'(q_res.size() + q_acc.size()), 32'd0);
        finish_run();
    end

endmodule